// File: doc/BRIEF.md
# Speculation Shadow Write Gate

This block sits beside one function unit and decides when the instruction that unit holds may write its result. At issue, the unit records which speculation sources still cover it: unresolved branches, pending predicate masks and instructions that might still raise an exception. Each such source later reports either success or failure. A failure on any source the unit is waiting on cancels the instruction: a one-cycle go-die pulse goes to the instruction and to its compute unit. Only when every recorded source has reported success, and any pending predicate has been decoded, does the unit present itself as writeable.

The instruction is treated as a set of element lanes that were allocated speculatively. When its predicate mask is decoded, each lane with a zero mask bit is cancelled with a per-lane die pulse, and each lane with a one bit keeps running. If the mask cancels every live lane, the whole instruction dies. After a cancellation, or after the writeable instruction reports that its write is complete, the unit drops all hold state and returns to idle, ready for the next issue.

Top module: `shadow_write_gate`

## Requirements
- R1: After reset, busy_o, writeable_o, go_die_o, hold_o, elem_live_o and elem_die_o are all zero.
- R2: An issue_i pulse while idle makes the unit busy on the next cycle, with hold_o equal to issue_shadow_i (bit i set means shadow source i is held) and elem_live_o equal to issue_elem_i (bit j set means lane j is allocated). An issue_i pulse while busy has no effect.
- R3: A success pulse on shadow_ok_i bit i clears hold_o bit i on the next cycle. A success or fail pulse on a source that is not held has no effect.
- R4: A fail pulse on any held source makes go_die_o high for exactly the next cycle, with elem_die_o equal to the lanes that were live, and the unit idle with all hold bits clear in that same cycle.
- R5: When a held source fails in the same cycle as any success pulses, on the same or other sources, the fail wins and R4 applies.
- R6: writeable_o is high exactly when the unit is busy, no hold bit is set and no predicate is pending (issue_pred_i at issue sets a pending predicate).
- R7: A pred_valid_i pulse while a predicate is pending clears the pending flag. On the next cycle elem_die_o pulses for one cycle with the live lanes whose pred_mask_i bit is zero, and elem_live_o keeps only the live lanes whose mask bit is one. A pred_valid_i pulse with no pending predicate has no effect.
- R8: If the decoded mask leaves no live lane, go_die_o pulses for one cycle and the unit returns to idle.
- R9: write_done_i while writeable returns the unit to idle on the next cycle; write_done_i while not writeable has no effect.
- R10: A held-source fail in the same cycle as a predicate decode cancels every live lane, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Issue pulse for a new instruction |
| issue_shadow_i | input | NSRC | Shadow sources active at issue |
| issue_pred_i | input | 1 | Instruction waits on a predicate mask |
| issue_elem_i | input | NELEM | Lanes allocated at issue |
| shadow_ok_i | input | NSRC | Per-source success pulses |
| shadow_fail_i | input | NSRC | Per-source fail pulses |
| pred_valid_i | input | 1 | Predicate mask decoded this cycle |
| pred_mask_i | input | NELEM | Decoded predicate mask, one bit per lane |
| write_done_i | input | 1 | Result write completed |
| busy_o | output | 1 | Unit holds an instruction |
| writeable_o | output | 1 | Instruction may write its result |
| hold_o | output | NSRC | Shadow sources still held |
| elem_live_o | output | NELEM | Lanes still live |
| go_die_o | output | 1 | One-cycle cancel of the whole instruction |
| elem_die_o | output | NELEM | One-cycle per-lane cancel |

## Verification
The bench sweeps every hold pattern with success pulses arriving in order, so a gate that opened early, or that let a success on an unheld source change anything, would show a wrong hold vector or an early writeable. It fails each held bit of every pattern while success pulses fire on all sources at once; a design that let success win would reach writeable instead of dying. Every pairing of allocated lanes and predicate mask is decoded, catching lanes killed or kept on the wrong bit and a fully cancelled mask that leaves a busy unit with no live lanes. Stray issue, completion and predicate pulses are sent while they must be ignored, and a fail coinciding with a decode must kill every lane, not only the masked ones.

// File: rtl/shadow_write_gate.sv
module shadow_write_gate #(
  parameter int NSRC  = 4,
  parameter int NELEM = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [NSRC-1:0]  issue_shadow_i,
  input  logic             issue_pred_i,
  input  logic [NELEM-1:0] issue_elem_i,
  input  logic [NSRC-1:0]  shadow_ok_i,
  input  logic [NSRC-1:0]  shadow_fail_i,
  input  logic             pred_valid_i,
  input  logic [NELEM-1:0] pred_mask_i,
  input  logic             write_done_i,
  output logic             busy_o,
  output logic             writeable_o,
  output logic [NSRC-1:0]  hold_o,
  output logic [NELEM-1:0] elem_live_o,
  output logic             go_die_o,
  output logic [NELEM-1:0] elem_die_o
);

  logic             busy_q, pend_q, die_q;
  logic [NSRC-1:0]  hold_q;
  logic [NELEM-1:0] live_q, edie_q;

  wire              held_fail = busy_q & (|(shadow_fail_i & hold_q));
  wire              pred_hit  = busy_q & pend_q & pred_valid_i;
  wire [NELEM-1:0]  kept      = live_q & pred_mask_i;
  wire              pred_kill = pred_hit & ~(|kept);
  wire              wr_ok     = busy_q & ~(|hold_q) & ~pend_q;
  wire              retire    = wr_ok & write_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      die_q  <= 1'b0;
      hold_q <= '0;
      live_q <= '0;
      edie_q <= '0;
    end else begin
      die_q  <= 1'b0;
      edie_q <= '0;
      if (!busy_q) begin
        if (issue_i) begin
          busy_q <= 1'b1;
          hold_q <= issue_shadow_i;
          pend_q <= issue_pred_i;
          live_q <= issue_elem_i;
        end
      end else if (held_fail || pred_kill) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
        hold_q <= '0;
        live_q <= '0;
        die_q  <= 1'b1;
        edie_q <= live_q;
      end else if (retire) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
        hold_q <= '0;
        live_q <= '0;
      end else begin
        hold_q <= hold_q & ~shadow_ok_i;
        if (pred_hit) begin
          pend_q <= 1'b0;
          live_q <= kept;
          edie_q <= live_q & ~pred_mask_i;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign writeable_o = wr_ok;
  assign hold_o      = hold_q;
  assign elem_live_o = live_q;
  assign go_die_o    = die_q;
  assign elem_die_o  = edie_q;

endmodule

// File: rtl/shadow_write_gate_chk.sv
module shadow_write_gate_chk #(
  parameter int NSRC  = 4,
  parameter int NELEM = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_i,
  input logic             busy_o,
  input logic             writeable_o,
  input logic [NSRC-1:0]  hold_o,
  input logic [NELEM-1:0] elem_live_o,
  input logic             go_die_o,
  input logic [NELEM-1:0] elem_die_o
);

  assert_die_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go_die_o |=> !go_die_o);

  assert_die_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go_die_o |-> (!busy_o && hold_o == '0 && elem_live_o == '0));

  assert_writeable_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    writeable_o |-> (busy_o && hold_o == '0));

  assert_hold_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ((hold_o & ~$past(hold_o)) == '0));

  assert_live_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ((elem_live_o & ~$past(elem_live_o)) == '0));

  assert_die_not_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_die_o & elem_live_o) == '0);

  assert_busy_ignores_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && issue_i) |=> ((hold_o & ~$past(hold_o)) == '0));

endmodule

bind shadow_write_gate shadow_write_gate_chk #(.NSRC(NSRC), .NELEM(NELEM)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .busy_o(busy_o),
  .writeable_o(writeable_o), .hold_o(hold_o), .elem_live_o(elem_live_o),
  .go_die_o(go_die_o), .elem_die_o(elem_die_o)
);

// File: tb/shadow_write_gate_tb.sv
`timescale 1ns/1ps
module shadow_write_gate_tb_top;
  localparam int NS = 4;
  localparam int NE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue = 0, ipred = 0, pvalid = 0, wdone = 0;
  logic [NS-1:0] ishadow = '0, ok = '0, fail = '0;
  logic [NE-1:0] ielem = '0, pmask = '0;
  logic busy, wr, die;
  logic [NS-1:0] hold;
  logic [NE-1:0] live, edie;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shadow_write_gate #(.NSRC(NS), .NELEM(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .issue_shadow_i(ishadow),
    .issue_pred_i(ipred), .issue_elem_i(ielem), .shadow_ok_i(ok),
    .shadow_fail_i(fail), .pred_valid_i(pvalid), .pred_mask_i(pmask),
    .write_done_i(wdone), .busy_o(busy), .writeable_o(wr), .hold_o(hold),
    .elem_live_o(live), .go_die_o(die), .elem_die_o(edie)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
    issue = 0; ok = '0; fail = '0; pvalid = 0; wdone = 0;
  endtask

  task automatic do_issue(logic [NS-1:0] h, logic p, logic [NE-1:0] e);
    issue = 1; ishadow = h; ipred = p; ielem = e;
    tick();
  endtask

  task automatic settle_idle;
    if (busy) begin wdone = 1; tick(); end
    if (busy) begin fail = '1; tick(); end
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 busy", busy, 0);
    chk("R1 writeable", wr, 0);
    chk("R1 hold", hold, 0);
    chk("R1 live", live, 0);
    chk("R1 go_die", die, 0);
    chk("R1 elem_die", edie, 0);

    // R2 R3 R6 R9: every hold pattern, successes in bit order
    for (int h = 0; h < 16; h++) begin
      logic [NS-1:0] exp_h;
      do_issue(h[NS-1:0], 0, 4'hF);
      exp_h = h[NS-1:0];
      chk("R2 busy", busy, 1);
      chk("R2 hold", hold, exp_h);
      chk("R2 live", live, 4'hF);
      chk("R6 writeable", wr, exp_h == 0);
      if (exp_h != 0) begin
        wdone = 1; tick();
        chk("R9 early done ignored", busy, 1);
      end
      for (int i = 0; i < NS; i++) begin
        ok[i] = 1'b1; tick();
        exp_h[i] = 1'b0;
        chk("R3 hold", hold, exp_h);
        chk("R6 writeable", wr, exp_h == 0);
        chk("R3 no die", die, 0);
      end
      fail[0] = 1'b1; ok = '1; tick();
      chk("R3 unheld fail ignored", die, 0);
      chk("R3 unheld busy", busy, 1);
      wdone = 1; tick();
      chk("R9 retire", busy, 0);
      chk("R9 hold", hold, 0);
      chk("R9 no die", die, 0);
      tick();
    end

    // R4 R5: fail each held bit while all sources succeed
    for (int h = 1; h < 16; h++) begin
      for (int f = 0; f < NS; f++) begin
        if (h[f]) begin
          do_issue(h[NS-1:0], 0, 4'b1011);
          fail[f] = 1'b1; ok = '1; tick();
          chk("R5 go_die", die, 1);
          chk("R4 elem_die", edie, 4'b1011);
          chk("R4 idle", busy, 0);
          chk("R4 hold", hold, 0);
          chk("R4 writeable", wr, 0);
          tick();
          chk("R4 single pulse", die, 0);
          chk("R4 elem pulse", edie, 0);
        end
      end
    end

    // R7 R8: every lane allocation against every mask
    for (int e = 0; e < 16; e++) begin
      for (int m = 0; m < 16; m++) begin
        logic [NE-1:0] ee, mm;
        ee = e[NE-1:0]; mm = m[NE-1:0];
        do_issue('0, 1, ee);
        chk("R6 pending blocks", wr, 0);
        wdone = 1; tick();
        chk("R9 done ignored pending", busy, 1);
        pvalid = 1; pmask = mm; tick();
        chk("R7 elem_die", edie, ee & ~mm);
        if ((ee & mm) == 0) begin
          chk("R8 go_die", die, 1);
          chk("R8 idle", busy, 0);
          tick();
        end else begin
          chk("R7 live", live, ee & mm);
          chk("R7 no go_die", die, 0);
          chk("R6 writeable", wr, 1);
          pvalid = 1; pmask = '0; tick();
          chk("R7 second mask ignored", live, ee & mm);
          chk("R7 no second die", edie, 0);
          wdone = 1; tick();
          chk("R9 retire", busy, 0);
          tick();
        end
      end
    end

    // R2: issue while busy ignored
    do_issue(4'b1010, 0, 4'b0011);
    do_issue(4'b0101, 1, 4'b1100);
    chk("R2 busy issue hold", hold, 4'b1010);
    chk("R2 busy issue live", live, 4'b0011);
    ok = 4'b1010; tick();
    chk("R2 busy issue no pred", wr, 1);
    settle_idle();

    // R10: fail with predicate decode
    do_issue(4'b0001, 1, 4'hF);
    pvalid = 1; pmask = 4'b0011; fail = 4'b0001; tick();
    chk("R10 go_die", die, 1);
    chk("R10 elem_die all", edie, 4'hF);
    chk("R10 idle", busy, 0);
    tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule